// File: doc/BRIEF.md
# Dual Event Counter with Atomic Snapshot

This block counts edges on two external event inputs, one 16-bit counter per input. Each input is first brought into the clock domain through a two-flop synchroniser. A per-counter polarity bit then chooses whether rising or falling edges are counted. Counters wrap silently at the top of their range. A single clock allows at most one increment per counter.

The host sees a small byte-wide register window. A control byte holds the two polarity bits and a capture bit. When the host writes the capture bit from 0 to 1, both live counts are copied in the same clock into a holding bank. The host then reads that bank as four consecutive bytes. The copy does not move while the host reads it, and the live counters keep counting underneath.

The host can also zero a counter. It does this by writing to either of that counter's snapshot byte addresses while the capture bit is clear.

Top module: `dual_event_snapshot`

## Requirements
- R1: After synchronous reset both counts, the control byte and the snapshot bank are zero, so reads of 0Ch through 10h all return 00h.
- R2: A counter adds one for each edge of its own input that matches its polarity bit (1 = rising, 0 = falling). Counter 1 uses control bit 0 and counter 2 uses control bit 1.
- R3: An edge of the opposite direction, or a change of the polarity bit while the input is steady, leaves the count unchanged.
- R4: An input change that is set up before clock edge k appears in the count at edge k+2. A capture written at edge k+2 therefore still holds the old value, and a capture at k+3 holds the new one.
- R5: A counter at FFFFh that sees one more qualifying edge becomes 0000h.
- R6: A host write to 0Ch that sets bit 3 while bit 3 is 0 copies both live counts into the snapshot bank. The bank reads back at 0Dh, 0Eh, 0Fh and 10h as counter 1 low byte, counter 1 high byte, counter 2 low byte and counter 2 high byte.
- R7: The snapshot bank changes only on the capture of R6. Holding bit 3 at 1, or rewriting it as 1, keeps the bank frozen while the live counts keep advancing.
- R8: With bit 3 clear, a write to 0Dh or 0Eh zeroes counter 1 and a write to 0Fh or 10h zeroes counter 2, whatever data is written. With bit 3 set, such writes are ignored.
- R9: Reading 0Ch returns the polarity bits at positions 0 and 1 and the capture bit at position 3, with all other bits 0. Reads of any address outside 0Ch through 10h return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 2 | Asynchronous event inputs; bit 0 feeds counter 1, bit 1 feeds counter 2 |
| reg_addr | input | 8 | Register byte address for reads and writes |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
The edge-origin assertion assumes that every event input level lasts at least one full clock period. A narrower glitch could be missed by the synchroniser, and the traced cause of an edge would then not match the input. The stimulus changes the event inputs only on falling clock edges and holds each level for at least one cycle, so every level is registered. The counter and snapshot assertions assume that the host write strobe is stable around the rising edge. The bench therefore drives the strobe, address and data from the falling edge and reads the combinational output after a short delay in the low phase.

// File: rtl/evs_pkg.sv
`timescale 1ns/1ps
package evs_pkg;
    localparam int CNT_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int NUM_CH     = 2;
    localparam int ADDR_W     = 8;
    localparam int CH_BYTES   = CNT_W / BYTE_W;
    localparam int SNAP_BYTES = NUM_CH * CH_BYTES;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h0C;
    localparam logic [ADDR_W-1:0] ADDR_SNAP0 = 8'h0D;

    // control byte bit positions: polarity for channel c sits at bit c
    localparam int BIT_CAP = 3;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [NUM_CH-1:0][CNT_W-1:0] count_bank_t;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic              cap;
        logic [NUM_CH-1:0] pol;
    } ctrl_t;

    function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prev);
        if (sel == EDGE_RISE)
            return cur & ~prev;
        else
            return ~cur & prev;
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(ctrl_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        for (int i = 0; i < NUM_CH; i++)
            b[i] = c.pol[i];
        b[BIT_CAP] = c.cap;
        return b;
    endfunction
endpackage

// File: rtl/evs_edge_detect.sv
`timescale 1ns/1ps
module evs_edge_detect
    import evs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  edge_sel_e sel,
    output logic      hit
);
    localparam int CHAIN_LEN = SYNC_STAGES + 1;

    logic [CHAIN_LEN-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[CHAIN_LEN-2:0], din};
    end

    assign hit = edge_hit(sel, chain[SYNC_STAGES-1], chain[SYNC_STAGES]);

    generate
        if (SYNC_STAGES == 2) begin : g_chk
            logic [1:0] age;
            always_ff @(posedge clk) begin
                if (rst)
                    age <= '0;
                else if (age != 2'd3)
                    age <= age + 2'd1;
            end
            // R4: a detected edge traces back to a change of din two and three cycles earlier
            p_edge_origin_r4: assert property (@(posedge clk) disable iff (rst)
                (hit && age == 2'd3) |-> ($past(din, 2) != $past(din, 3)));
        end
    endgenerate
endmodule

// File: rtl/evs_counter.sv
`timescale 1ns/1ps
module evs_counter
    import evs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   inc,
    input  logic   clr,
    output count_t count
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc)
            count <= count + count_t'(1);
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (count == count_t'($past(count) + count_t'(1))));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(count));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));
endmodule

// File: rtl/evs_regfile.sv
`timescale 1ns/1ps
module evs_regfile
    import evs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  count_bank_t       live,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pol,
    output logic [NUM_CH-1:0] clr
);
    ctrl_t             ctrl_q;
    count_bank_t       snap_q;
    logic              ctrl_hit;
    logic              capture;
    logic              in_snap;
    logic [ADDR_W-1:0] off;
    logic              unused_wdata;

    assign ctrl_hit     = (reg_addr == ADDR_CTRL);
    assign off          = reg_addr - ADDR_SNAP0;
    assign in_snap      = (reg_addr >= ADDR_SNAP0) && (int'(off) < SNAP_BYTES);
    assign capture      = reg_wr && ctrl_hit && reg_wdata[BIT_CAP] && !ctrl_q.cap;
    assign pol          = ctrl_q.pol;
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (reg_wr && ctrl_hit) begin
            ctrl_q.cap <= reg_wdata[BIT_CAP];
            ctrl_q.pol <= reg_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (capture)
            snap_q <= live;
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
            assign clr[c] = reg_wr && !ctrl_q.cap && in_snap
                            && ((int'(off) / CH_BYTES) == c);
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (ctrl_hit)
            reg_rdata = ctrl_to_byte(ctrl_q);
        else if (in_snap)
            reg_rdata = snap_q[int'(off) / CH_BYTES][(int'(off) % CH_BYTES) * BYTE_W +: BYTE_W];
    end

    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        capture |=> (snap_q == $past(live)));

    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(snap_q));
endmodule

// File: rtl/dual_event_snapshot.sv
`timescale 1ns/1ps
module dual_event_snapshot
    import evs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ev_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata
);
    logic [NUM_CH-1:0] pol;
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] hit;
    count_bank_t       live;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            evs_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk (clk),
                .rst (rst),
                .din (ev_in[c]),
                .sel (edge_sel_e'(pol[c])),
                .hit (hit[c])
            );
            evs_counter u_cnt (
                .clk   (clk),
                .rst   (rst),
                .inc   (hit[c]),
                .clr   (clr[c]),
                .count (live[c])
            );
        end
    endgenerate

    evs_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .live      (live),
        .reg_rdata (reg_rdata),
        .pol       (pol),
        .clr       (clr)
    );
endmodule

// File: tb/dual_event_snapshot_test.sv
`timescale 1ns/1ps
module dual_event_snapshot_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ev_in = 2'b00;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int total = 0;
    int fails = 0;
    bit done = 0;
    int exp_cnt [2];
    int exp_snap [2];
    logic [1:0] pol_m = 2'b00;

    always #10 clk = ~clk;

    dual_event_snapshot uut (
        .clk(clk), .rst(rst), .ev_in(ev_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(string tag, int act, int expv);
        total++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic set_ev(logic [1:0] v);
        @(negedge clk);
        for (int c = 0; c < 2; c++)
            if (ev_in[c] != v[c] && (v[c] == pol_m[c]))
                exp_cnt[c] = (exp_cnt[c] + 1) & 16'hFFFF;
        ev_in = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #2 v = int'(reg_rdata);
    endtask

    task automatic set_ctrl(logic [1:0] p, logic cap);
        wr(8'h0C, {4'b0000, cap, 1'b0, p});
        pol_m = p;
    endtask

    task automatic capture();
        set_ctrl(pol_m, 1'b0);
        set_ctrl(pol_m, 1'b1);
        exp_snap[0] = exp_cnt[0];
        exp_snap[1] = exp_cnt[1];
    endtask

    task automatic check_snap(string tag);
        int v;
        rd(8'h0D, v); check({tag, " c1 lo"}, v, exp_snap[0] & 8'hFF);
        rd(8'h0E, v); check({tag, " c1 hi"}, v, (exp_snap[0] >> 8) & 8'hFF);
        rd(8'h0F, v); check({tag, " c2 lo"}, v, exp_snap[1] & 8'hFF);
        rd(8'h10, v); check({tag, " c2 hi"}, v, (exp_snap[1] >> 8) & 8'hFF);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int v;
        int old;
        exp_cnt[0] = 0; exp_cnt[1] = 0;
        exp_snap[0] = 0; exp_snap[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: everything zero after reset
        for (int a = 8'h0C; a <= 8'h10; a++) begin
            rd(8'(a), v); check("R1 reset read", v, 0);
        end

        // R9: control readback, reserved bits, out-of-window reads
        wr(8'h0C, 8'hFF);
        rd(8'h0C, v); check("R9 ctrl readback", v, 8'h0B);
        rd(8'h00, v); check("R9 outside 00h", v, 0);
        rd(8'h0B, v); check("R9 outside 0Bh", v, 0);
        rd(8'h11, v); check("R9 outside 11h", v, 0);
        pol_m = 2'b11;
        set_ctrl(2'b00, 1'b0);
        rd(8'h0C, v); check("R9 ctrl cleared", v, 0);

        // R2 R3: sweep over polarity pairs and pulse lengths
        for (int p = 0; p < 4; p++) begin
            set_ctrl(2'(p), 1'b0);
            wr(8'h0D, 8'hA5); wr(8'h10, 8'h3C);
            exp_cnt[0] = 0; exp_cnt[1] = 0;
            for (int n = 1; n <= 6; n++) begin
                for (int k = 1; k <= n * 2 + p; k++)
                    set_ev(2'(k));
                settle();
                capture();
                check_snap("R2 R3 sweep");
            end
            set_ctrl(2'(p), 1'b0);
            set_ctrl(~2'(p), 1'b0);
            settle();
            capture();
            check_snap("R3 polarity flip no count");
        end

        // R4: latency of the synchroniser and counter
        set_ctrl(2'b11, 1'b0);
        set_ev(2'b00);
        settle();
        for (int d = 2; d <= 3; d++) begin
            set_ctrl(2'b11, 1'b0);
            old = exp_cnt[0];
            @(negedge clk);
            ev_in = 2'b01;
            repeat (d) @(negedge clk);
            reg_addr = 8'h0C; reg_wdata = 8'h0B; reg_wr = 1'b1;
            @(negedge clk);
            reg_wr = 1'b0;
            exp_cnt[0] = (old + 1) & 16'hFFFF;
            rd(8'h0D, v);
            check(d == 2 ? "R4 capture at k+2 old" : "R4 capture at k+3 new", v,
                  (d == 2 ? old : old + 1) & 8'hFF);
            set_ev(2'b00);
            settle();
        end

        // R5: wrap, counter 1 rising and counter 2 falling on the same toggles
        set_ctrl(2'b01, 1'b0);
        wr(8'h0E, 8'h00); wr(8'h0F, 8'h00);
        exp_cnt[0] = 0; exp_cnt[1] = 0;
        for (int i = 0; i < 65535; i++) begin
            set_ev(2'b11);
            set_ev(2'b00);
        end
        settle();
        capture();
        check_snap("R5 at FFFFh");
        set_ev(2'b11);
        set_ev(2'b00);
        settle();
        capture();
        check_snap("R5 wrapped to 0000h");

        // R7: frozen snapshot while bit 3 held, live counts keep going
        set_ctrl(2'b11, 1'b0);
        capture();
        for (int i = 0; i < 3; i++) begin
            set_ev(2'b11);
            set_ev(2'b00);
        end
        settle();
        check_snap("R7 frozen while held");
        set_ctrl(2'b11, 1'b1);
        check_snap("R7 rewrite of set bit");
        // R8: clears ignored while bit 3 set
        wr(8'h0D, 8'hFF); wr(8'h0F, 8'hFF);
        capture();
        check_snap("R7 R8 counting continued, clear ignored");

        // R8: clears with bit 3 clear
        set_ctrl(2'b11, 1'b0);
        wr(8'h0E, 8'h55);
        exp_cnt[0] = 0;
        capture();
        check_snap("R8 clear counter 1 only");
        set_ctrl(2'b11, 1'b0);
        wr(8'h0F, 8'h00);
        exp_cnt[1] = 0;
        capture();
        check_snap("R8 clear counter 2");

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule